// File: doc/BRIEF.md
# Unaligned Word Load/Store Merger

This unit performs the four partial-word memory operations on a bus that only moves whole 32-bit words. The two load forms fill the high end or the low end of a register from a word fetched from memory. The two store forms place the high end or the low end of a register into a word in memory. The effective address is formed from a base value plus a sign-extended 16-bit offset. The bus is always accessed at that address with its two lowest bits cleared. The two dropped bits form the lane number k, and k decides how many bytes come from each side.

A command is accepted through a valid/ready handshake. `cmd_ready` is high only while the unit is idle, so at most one operation is in flight. A command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high, and the command fields are sampled on that edge. The memory side is a request/acknowledge bus. The request and its address, direction and write data stay unchanged until the cycle in which `mem_ack` is high, and `mem_rdata` is sampled in that cycle. Load results leave through a valid/ready output. `res_valid` stays high with stable data until `res_ready` is seen, so a consumer may stall the unit for as long as it likes. `done` pulses for one cycle as each operation retires.

Top module: `uaw_merge_unit`

## Requirements
- R1: The bus address is (base + sign-extended offset) with bits 1:0 forced to zero, and k is bits 1:0 of that sum.
- R2: Load-high (op 2'b00) returns (mem << 8*(3-k)) OR (reg AND the mask keeping the low 3-k bytes).
- R3: Load-low (op 2'b01) returns (mem >> 8*k) OR (reg AND the mask keeping the high k bytes).
- R4: Store-high (op 2'b10) writes (reg >> 8*(3-k)) OR (mem AND the mask keeping the high 3-k bytes). The write goes to the same aligned address that was read just before.
- R5: Store-low (op 2'b11) writes (reg << 8*k) OR (mem AND the mask keeping the low k bytes). It is a read of the aligned word followed by a write to the same address.
- R6: `cmd_ready` is high exactly when no operation is in progress. Loads issue one read. Stores issue one read and then one write.
- R7: While `mem_req` is high without `mem_ack`, the request, `mem_we`, `mem_addr` and `mem_wdata` hold their values into the next cycle.
- R8: Each load whose destination index is not zero raises `res_valid` once. `res_valid` and `res_data` stay stable until a cycle with `res_ready` high. Stores never raise `res_valid`.
- R9: A load whose destination index `cmd_dst` is 0 still performs its read, but `res_valid` stays low for it. `cmd_dst` has no effect on stores.
- R10: `done` is high for one cycle. That cycle is the one where a store's write is acknowledged, where a load result is accepted, or the cycle right after the read for a load to destination 0.
- R11: After reset `cmd_ready` is 1 and `mem_req`, `res_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle, command accepted when valid is also high |
| cmd_op | input | 2 | 00 load-high, 01 load-low, 10 store-high, 11 store-low |
| cmd_base | input | 32 | Base address |
| cmd_ofs | input | 16 | Signed address offset |
| cmd_reg | input | 32 | Current register value (merge source for loads, data for stores) |
| cmd_dst | input | 5 | Destination register index for loads |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned bus address |
| mem_wdata | output | 32 | Merged word to write |
| mem_ack | input | 1 | Bus completes the request this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| res_valid | output | 1 | Load result available |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 32 | Merged load result |
| done | output | 1 | One-cycle retire pulse |

## Verification
The bench drives every op at all four lane values. It also uses negative offsets that borrow across the alignment boundary. A design that used the raw sum, or the wrong bits of it, would show a bad bus address or a wrong merge. Stores are checked against a bench memory, so a write with stale read data or with the wrong keep-mask leaves wrong bytes behind. These show up when a later load reads the same word. Random acknowledge delays and random result back-pressure reveal a request or result that drifts while it waits. Loads to destination 0 check that the read still happens with no result raised, and that `done` still fires instead of leaving the unit stuck.

// File: rtl/uaw_pkg.sv
package uaw_pkg;
  typedef enum logic [1:0] {
    OP_LD_HI = 2'b00,
    OP_LD_LO = 2'b01,
    OP_ST_HI = 2'b10,
    OP_ST_LO = 2'b11
  } uaw_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RD   = 2'b01,
    ST_WR   = 2'b10,
    ST_DONE = 2'b11
  } uaw_state_e;

  function automatic logic op_is_store(uaw_op_e op);
    return op[1];
  endfunction
endpackage

// File: rtl/uaw_addr_gen.sv
module uaw_addr_gen #(
  parameter int AW = 32,
  parameter int OW = 16,
  parameter int LW = 2
) (
  input  logic [AW-1:0] base,
  input  logic [OW-1:0] ofs,
  output logic [AW-1:0] word_addr,
  output logic [LW-1:0] lane
);
  logic [AW-1:0] eff;

  assign eff       = base + {{(AW-OW){ofs[OW-1]}}, ofs};
  assign word_addr = {eff[AW-1:LW], {LW{1'b0}}};
  assign lane      = eff[LW-1:0];
endmodule

// File: rtl/uaw_merge.sv
module uaw_merge
  import uaw_pkg::*;
#(
  parameter int DW = 32,
  parameter int LW = $clog2(DW/8)
) (
  input  uaw_op_e       op,
  input  logic [LW-1:0] lane,
  input  logic [DW-1:0] regv,
  input  logic [DW-1:0] memw,
  output logic [DW-1:0] merged
);
  localparam int NB  = DW / 8;
  localparam int SHW = $clog2(DW) + 1;

  logic [SHW-1:0] sh_up;
  logic [SHW-1:0] sh_dn;
  logic [DW-1:0]  ones;

  assign ones  = '1;
  assign sh_up = SHW'(lane) << 3;
  assign sh_dn = SHW'(8 * (NB - 1)) - sh_up;

  always_comb begin
    unique case (op)
      OP_LD_HI: merged = (memw << sh_dn) | (regv & (ones >> (sh_up + SHW'(8))));
      OP_LD_LO: merged = (memw >> sh_up) | (regv & ~(ones >> sh_up));
      OP_ST_HI: merged = (regv >> sh_dn) | (memw & ~(ones >> sh_dn));
      OP_ST_LO: merged = (regv << sh_up) | (memw & ~(ones << sh_up));
      default:  merged = memw;
    endcase
  end
endmodule

// File: rtl/uaw_ctrl.sv
module uaw_ctrl
  import uaw_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  uaw_op_e       cmd_op,
  input  logic [AW-1:0] cmd_waddr,
  input  logic [LW-1:0] cmd_lane,
  input  logic [DW-1:0] cmd_reg,
  input  logic          cmd_dst_zero,
  output uaw_op_e       mg_op,
  output logic [LW-1:0] mg_lane,
  output logic [DW-1:0] mg_reg,
  input  logic [DW-1:0] mg_out,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [DW-1:0] res_data,
  output logic          done
);
  uaw_state_e    st;
  uaw_op_e       op_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] lane_q;
  logic [DW-1:0] reg_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] res_q;
  logic          zero_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      op_q    <= OP_LD_HI;
      addr_q  <= '0;
      lane_q  <= '0;
      reg_q   <= '0;
      wdata_q <= '0;
      res_q   <= '0;
      zero_q  <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (cmd_valid) begin
          op_q   <= cmd_op;
          addr_q <= cmd_waddr;
          lane_q <= cmd_lane;
          reg_q  <= cmd_reg;
          zero_q <= cmd_dst_zero & ~op_is_store(cmd_op);
          st     <= ST_RD;
        end
        ST_RD: if (mem_ack) begin
          if (op_is_store(op_q)) begin
            wdata_q <= mg_out;
            st      <= ST_WR;
          end else begin
            res_q <= mg_out;
            st    <= ST_DONE;
          end
        end
        ST_WR: if (mem_ack) st <= ST_IDLE;
        ST_DONE: if (zero_q || res_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (st == ST_IDLE);
  assign mg_op     = op_q;
  assign mg_lane   = lane_q;
  assign mg_reg    = reg_q;
  assign mem_req   = (st == ST_RD) || (st == ST_WR);
  assign mem_we    = (st == ST_WR);
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign res_valid = (st == ST_DONE) && !zero_q;
  assign res_data  = res_q;
  assign done      = ((st == ST_WR) && mem_ack) ||
                     ((st == ST_DONE) && (zero_q || res_ready));

  // R1
  mem_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[LW-1:0] == '0));

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) &&
                               $stable(mem_addr) && $stable(mem_wdata)));

  // R4
  wr_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $stable(mem_addr));

  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!mem_req && !res_valid));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/uaw_merge_unit.sv
module uaw_merge_unit
  import uaw_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int OW = 16,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_base,
  input  logic [OW-1:0] cmd_ofs,
  input  logic [DW-1:0] cmd_reg,
  input  logic [RW-1:0] cmd_dst,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [DW-1:0] res_data,
  output logic          done
);
  localparam int LW = $clog2(DW / 8);

  logic [AW-1:0] waddr;
  logic [LW-1:0] lane;
  uaw_op_e       mg_op;
  logic [LW-1:0] mg_lane;
  logic [DW-1:0] mg_reg;
  logic [DW-1:0] mg_out;

  uaw_addr_gen #(.AW(AW), .OW(OW), .LW(LW)) agen_i (
    .base(cmd_base), .ofs(cmd_ofs), .word_addr(waddr), .lane(lane)
  );

  uaw_merge #(.DW(DW), .LW(LW)) merge_i (
    .op(mg_op), .lane(mg_lane), .regv(mg_reg), .memw(mem_rdata), .merged(mg_out)
  );

  uaw_ctrl #(.AW(AW), .DW(DW), .LW(LW)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(uaw_op_e'(cmd_op)), .cmd_waddr(waddr), .cmd_lane(lane),
    .cmd_reg(cmd_reg), .cmd_dst_zero(cmd_dst == '0),
    .mg_op(mg_op), .mg_lane(mg_lane), .mg_reg(mg_reg), .mg_out(mg_out),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .done(done)
  );
endmodule

// File: tb/uaw_merge_unit_tb.sv
module uaw_merge_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = '0;
  logic [31:0] cmd_base = '0;
  logic [15:0] cmd_ofs = '0;
  logic [31:0] cmd_reg = '0;
  logic [4:0]  cmd_dst = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [31:0] res_data;
  logic        done;

  always #(CLK_PERIOD/2) clk = ~clk;

  uaw_merge_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_base(cmd_base), .cmd_ofs(cmd_ofs), .cmd_reg(cmd_reg),
    .cmd_dst(cmd_dst), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data), .done(done)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference merges, written as per-lane tables
  function automatic logic [31:0] ref_merge(input logic [1:0] op, input logic [1:0] k,
                                            input logic [31:0] r, input logic [31:0] m);
    logic [31:0] res;
    case (op)
      2'b00: case (k)
        2'd0: res = {m[7:0],  r[23:0]};
        2'd1: res = {m[15:0], r[15:0]};
        2'd2: res = {m[23:0], r[7:0]};
        default: res = m;
      endcase
      2'b01: case (k)
        2'd0: res = m;
        2'd1: res = {r[31:24], m[31:8]};
        2'd2: res = {r[31:16], m[31:16]};
        default: res = {r[31:8], m[31:24]};
      endcase
      2'b10: case (k)
        2'd0: res = {m[31:8],  r[31:24]};
        2'd1: res = {m[31:16], r[31:16]};
        2'd2: res = {m[31:24], r[31:8]};
        default: res = r;
      endcase
      default: case (k)
        2'd0: res = r;
        2'd1: res = {r[23:0], m[7:0]};
        2'd2: res = {r[15:0], m[15:0]};
        default: res = {r[7:0], m[23:0]};
      endcase
    endcase
    return res;
  endfunction

  function automatic string op_req(input logic [1:0] op);
    case (op)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  logic [31:0] bmem [16];

  // model state
  int          ph = 0;        // 0 idle, 1 read, 2 write, 3 result, 4 zero-dest retire
  int          dly = 0;
  bit          acc_p = 0, ack_p = 0, hs_p = 0;
  logic [1:0]  c_op;
  logic [31:0] c_base, c_reg;
  logic [15:0] c_ofs;
  logic [4:0]  c_dst;
  bit          c_zero;
  logic [31:0] e_addr, e_val;
  logic [1:0]  e_k;

  always begin
    @(negedge clk);
    #1;
    if (!rst_n) begin
      mem_ack = 1'b0;
      ph = 0; acc_p = 0; ack_p = 0; hs_p = 0;
      chk("R11 cmd_ready", {31'd0, cmd_ready}, 32'd1);
      chk("R11 mem_req",   {31'd0, mem_req},   32'd0);
      chk("R11 res_valid", {31'd0, res_valid}, 32'd0);
      chk("R11 done",      {31'd0, done},      32'd0);
    end else begin
      // advance the model by what happened at the last edge
      case (ph)
        1: if (ack_p) ph = c_op[1] ? 2 : (c_zero ? 4 : 3);
        2: if (ack_p) ph = 0;
        3: if (hs_p) ph = 0;
        4: ph = 0;
        default: ;
      endcase
      if (acc_p) begin
        logic [31:0] ea;
        ea     = c_base + {{16{c_ofs[15]}}, c_ofs};
        e_addr = {ea[31:2], 2'b00};
        e_k    = ea[1:0];
        e_val  = ref_merge(c_op, e_k, c_reg, bmem[e_addr[5:2]]);
        c_zero = !c_op[1] && (c_dst == 5'd0);
        ph     = 1;
      end
      // bus responder and result consumer
      if (ph == 1 || ph == 2) begin
        if (dly == 0) begin
          mem_ack = 1'b1;
          dly = $urandom_range(0, 2);
        end else begin
          mem_ack = 1'b0;
          dly--;
        end
      end else mem_ack = 1'b0;
      mem_rdata = (mem_ack && ph == 1) ? bmem[e_addr[5:2]] : 32'hA5A5_5A5A;
      res_ready = ($urandom_range(0, 3) != 0);
      #1;
      // per-cycle comparison
      chk("R6 cmd_ready", {31'd0, cmd_ready}, {31'd0, ph == 0});
      chk("R6 mem_req", {31'd0, mem_req}, {31'd0, (ph == 1 || ph == 2)});
      if (ph == 1 || ph == 2) begin
        chk("R1 mem_addr", mem_addr, e_addr);
        chk("R6 mem_we", {31'd0, mem_we}, {31'd0, ph == 2});
      end
      if (ph == 2) chk(op_req(c_op), mem_wdata, e_val);
      chk(ph == 4 ? "R9 res_valid" : "R8 res_valid", {31'd0, res_valid}, {31'd0, ph == 3});
      if (ph == 3) chk(op_req(c_op), res_data, e_val);
      chk("R10 done", {31'd0, done},
          {31'd0, (ph == 2 && mem_ack) || (ph == 3 && res_ready) || ph == 4});
      if (ph == 2 && mem_ack) bmem[e_addr[5:2]] = e_val;
      // record what the coming edge will do
      acc_p = cmd_valid && cmd_ready;
      if (acc_p) begin
        c_op = cmd_op; c_base = cmd_base; c_ofs = cmd_ofs; c_reg = cmd_reg; c_dst = cmd_dst;
      end
      ack_p = mem_ack;
      hs_p  = res_valid && res_ready;
    end
  end

  task automatic send(input logic [1:0] op, input logic [31:0] base, input logic [15:0] ofs,
                      input logic [31:0] r, input logic [4:0] dst);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_base = base; cmd_ofs = ofs; cmd_reg = r; cmd_dst = dst;
    forever begin
      @(posedge clk);
      if (acc_p) break;
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op = 2'($urandom); cmd_base = $urandom; cmd_reg = $urandom; cmd_dst = 5'($urandom);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog expired: actual=hung expected=finished");
    report();
  end

  initial begin
    for (int i = 0; i < 16; i++) bmem[i] = 32'h1122_3344 ^ (i * 32'h0F0F_1357);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 R3 R4 R5: every op at every lane, positive offset
    for (int op = 0; op < 4; op++)
      for (int k = 0; k < 4; k++)
        send(2'(op), 32'h0000_1000, 16'(4 * op + k), 32'hAABB_CCDD, 5'd7);
    // R1: negative offsets borrowing across the alignment boundary
    send(2'b00, 32'h0000_2020, 16'hFFF1, 32'h0102_0304, 5'd3);
    send(2'b11, 32'h0000_2020, 16'hFFFE, 32'hCAFE_F00D, 5'd3);
    send(2'b01, 32'h0000_2020, 16'hFFFE, 32'h5555_AAAA, 5'd3);
    send(2'b10, 32'h8000_0001, 16'h8000, 32'h1357_9BDF, 5'd0);
    // R9: loads to register zero, and stores with dst 0
    for (int k = 0; k < 4; k++) send(2'(k & 1), 32'h0000_3000, 16'(k), 32'hFFFF_0000, 5'd0);
    send(2'b11, 32'h0000_3001, 16'h0000, 32'h7777_8888, 5'd0);
    // random traffic, including read-back of stored words
    for (int i = 0; i < 200; i++)
      send(2'($urandom), {26'($urandom), 6'($urandom)}, 16'($urandom), $urandom, 5'($urandom_range(0, 3)));
    repeat (12) @(negedge clk);
    report();
  end
endmodule